// File: doc/BRIEF.md
# Graphics Packet Tag Unpacker

This block sits on a 128-bit quadword stream that carries graphics command packets. The first quadword it takes is a tag. The tag sets a loop count, a per-loop register count, a transfer mode, an end-of-packet flag and an optional primitive preset. The tag also holds up to sixteen 4-bit register descriptors, which are replayed on every loop.

In packed mode, each following data quadword is converted according to its descriptor. The result is one register write, made of a 7-bit address and 64-bit data, sent to a downstream register bank. One descriptor code lets the payload carry its own target address, so any register can be reached through it.

The other transfer modes are consumed and skipped without producing writes. When a tag's quadwords are all consumed, the block expects the next tag.

Top module: `gpkt_unpack`

## Requirements
- R1: After reset no strobe is active, and the first accepted quadword is taken as a tag. Tag fields: loop count in bits 14:0, end flag in bit 15, preset enable in bit 46, preset value in bits 57:47, mode in bits 59:58 (0 packed, 1 list, 2 image, 3 reserved), register count in bits 63:60, descriptors in bits 127:64.
- R2: When the preset enable bit is set, `prim_en` pulses with `prim_data` equal to tag bits 57:47 in the cycle after the tag is accepted. This comes before any write from that tag's data.
- R3: A packed tag consumes loops × count data quadwords. The descriptor for each quadword is taken in order from the least significant nibble upward, restarting at nibble 0 on each loop. A count of 0 means 16.
- R4: Descriptor 0x1 writes address 0x01 with data bits 31:0 = {q[103:96], q[71:64], q[39:32], q[7:0]} and the upper 32 bits zero.
- R5: Descriptors 0x4 and 0xC write {q[107:100], q[91:68], q[47:32], q[15:0]}. Descriptors 0x5 and 0xD write {q[95:64], q[47:32], q[15:0]}. The address is the descriptor code, except that 0x4 and 0x5 become 0x0C and 0x0D when q[111] is set.
- R6: Descriptor 0xE writes address q[70:64] with data q[63:0].
- R7: Descriptors 0xF and 0xB consume their quadword and produce no write.
- R8: Descriptor 0x0 writes q[10:0] zero-extended to address 0x00. Descriptors 0x2 and 0x6–0x9 write q[63:0] to the address equal to the code. Descriptor 0x3 writes q[13:0] to data bits 13:0 and q[45:32] to data bits 29:16. Descriptor 0xA writes q[107:100] to data bits 63:56.
- R9: Mode 1 skips ceil(loops × count / 2) quadwords, and modes 2 and 3 skip loops quadwords, all without writes.
- R10: A tag with a loop count of 0 consumes no data quadwords, and the next quadword is a tag.
- R11: `pkt_end` pulses for one cycle after the last quadword of a tag whose end flag is set, or after the tag itself when it has no data.
- R12: `qw_ready` is always high, and each write appears in the cycle after its data quadword is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qw_valid | input | 1 | Quadword valid |
| qw_data | input | 128 | Quadword payload |
| qw_ready | output | 1 | Quadword accepted when high with valid |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 7 | Register write address |
| wr_data | output | 64 | Register write data |
| prim_en | output | 1 | Primitive preset strobe |
| prim_data | output | 11 | Primitive preset value |
| pkt_end | output | 1 | End-of-packet pulse |

## Verification
The assertions assume that `qw_valid` is never unknown while reset is released. They also assume that every strobe is caused by a quadword accepted in the cycle before it. The stimulus holds `qw_valid` low during reset and changes it only on falling edges. It inserts idle gaps between quadwords without ever presenting a partial tag. Every tag it sends is followed by exactly the number of quadwords that the tag's mode and counts require.

// File: rtl/gpkt_unpack.sv
module gpkt_unpack (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         qw_valid,
  input  logic [127:0] qw_data,
  output logic         qw_ready,
  output logic         wr_en,
  output logic [6:0]   wr_addr,
  output logic [63:0]  wr_data,
  output logic         prim_en,
  output logic [10:0]  prim_data,
  output logic         pkt_end
);
  assign qw_ready = 1'b1;
  wire fire = qw_valid & qw_ready;

  logic        busy, packed_m, eop_l;
  logic [19:0] left;
  logic [3:0]  idx, last_idx;
  logic [63:0] descs;

  wire [14:0] t_loops = qw_data[14:0];
  wire        t_eop   = qw_data[15];
  wire        t_pre   = qw_data[46];
  wire [10:0] t_prim  = qw_data[57:47];
  wire [1:0]  t_mode  = qw_data[59:58];
  wire [3:0]  t_nreg  = qw_data[63:60];
  wire [4:0]  t_nr    = (t_nreg == 4'd0) ? 5'd16 : {1'b0, t_nreg};
  wire [19:0] t_prod  = 20'(t_loops) * 20'(t_nr);

  logic [19:0] t_count;
  always_comb begin
    case (t_mode)
      2'd0:    t_count = t_prod;
      2'd1:    t_count = (t_prod + 20'd1) >> 1;
      default: t_count = 20'(t_loops);
    endcase
  end

  wire [63:0] sh   = descs >> {idx, 2'b00};
  wire [3:0]  code = sh[3:0];
  wire        adc  = qw_data[111];

  logic        c_we;
  logic [6:0]  c_addr;
  logic [63:0] c_data;
  always_comb begin
    c_we   = 1'b1;
    c_addr = {3'b000, code};
    c_data = qw_data[63:0];
    case (code)
      4'h0: c_data = {53'd0, qw_data[10:0]};
      4'h1: c_data = {32'd0, qw_data[103:96], qw_data[71:64], qw_data[39:32], qw_data[7:0]};
      4'h3: c_data = {34'd0, qw_data[45:32], 2'b00, qw_data[13:0]};
      4'h4, 4'hC: begin
        c_data = {qw_data[107:100], qw_data[91:68], qw_data[47:32], qw_data[15:0]};
        if (code == 4'h4 && adc) c_addr = 7'h0C;
      end
      4'h5, 4'hD: begin
        c_data = {qw_data[95:64], qw_data[47:32], qw_data[15:0]};
        if (code == 4'h5 && adc) c_addr = 7'h0D;
      end
      4'hA: c_data = {qw_data[107:100], 56'd0};
      4'hE: c_addr = qw_data[70:64];
      4'hB, 4'hF: c_we = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; packed_m <= 1'b0; eop_l <= 1'b0;
      left <= '0; idx <= '0; last_idx <= '0; descs <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      prim_en <= 1'b0; prim_data <= '0; pkt_end <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      prim_en <= 1'b0;
      pkt_end <= 1'b0;
      if (fire) begin
        if (!busy) begin
          descs    <= qw_data[127:64];
          last_idx <= t_nreg - 4'd1;
          idx      <= '0;
          packed_m <= (t_mode == 2'd0);
          eop_l    <= t_eop;
          left     <= t_count;
          busy     <= (t_count != 20'd0);
          if (t_pre) begin
            prim_en   <= 1'b1;
            prim_data <= t_prim;
          end
          if (t_count == 20'd0) pkt_end <= t_eop;
        end else begin
          left <= left - 20'd1;
          idx  <= (idx == last_idx) ? 4'd0 : idx + 4'd1;
          if (packed_m && c_we) begin
            wr_en   <= 1'b1;
            wr_addr <= c_addr;
            wr_data <= c_data;
          end
          if (left == 20'd1) begin
            busy    <= 1'b0;
            pkt_end <= eop_l;
          end
        end
      end
    end
  end
endmodule

module gpkt_unpack_chk (
  input logic clk,
  input logic rst_n,
  input logic qw_valid,
  input logic qw_ready,
  input logic wr_en,
  input logic prim_en,
  input logic pkt_end
);
  // R12
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) qw_ready);
  // R12
  write_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(qw_valid && qw_ready));
  // R2
  preset_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prim_en |-> $past(qw_valid && qw_ready));
  // R2
  preset_not_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prim_en && wr_en));
  // R11
  end_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> $past(qw_valid && qw_ready));
endmodule

bind gpkt_unpack gpkt_unpack_chk chk_i (
  .clk(clk), .rst_n(rst_n), .qw_valid(qw_valid), .qw_ready(qw_ready),
  .wr_en(wr_en), .prim_en(prim_en), .pkt_end(pkt_end)
);

// File: tb/gpkt_unpack_tb_top.sv
module gpkt_unpack_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         qw_valid = 1'b0;
  logic [127:0] qw_data = '0;
  logic         qw_ready, wr_en, prim_en, pkt_end;
  logic [6:0]   wr_addr;
  logic [63:0]  wr_data;
  logic [10:0]  prim_data;

  always #2 clk = ~clk;

  gpkt_unpack dut_i (
    .clk(clk), .rst_n(rst_n), .qw_valid(qw_valid), .qw_data(qw_data),
    .qw_ready(qw_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prim_en(prim_en), .prim_data(prim_data), .pkt_end(pkt_end)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit run = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          kind;
    logic [6:0]  addr;
    logic [63:0] data;
    int          cyc;
    string       req;
  } ev_t;
  ev_t expq[$];

  function automatic void push(int kind, logic [6:0] a, logic [63:0] d, string r);
    ev_t e;
    e.kind = kind; e.addr = a; e.data = d; e.cyc = cyc; e.req = r;
    expq.push_back(e);
  endfunction

  // Reference model state
  bit          m_busy = 0, m_packed = 0, m_eop = 0;
  int          m_left = 0, m_idx = 0, m_nr = 0;
  logic [63:0] m_regs = '0;

  function automatic bit ref_conv(logic [3:0] c, logic [127:0] q,
                                  output logic [6:0] a, output logic [63:0] d,
                                  output string r);
    a = {3'b000, c};
    d = q[63:0];
    r = "R8";
    if (c == 4'hF || c == 4'hB) return 0;
    case (c)
      4'h0: d = q[63:0] & 64'h7FF;
      4'h1: begin
        d = 64'd0;
        d[7:0] = q[7:0]; d[15:8] = q[39:32]; d[23:16] = q[71:64]; d[31:24] = q[103:96];
        r = "R4";
      end
      4'h3: begin d = 64'd0; d[13:0] = q[13:0]; d[29:16] = q[45:32]; end
      4'h4, 4'hC: begin
        d[15:0] = q[15:0]; d[31:16] = q[47:32]; d[55:32] = q[91:68]; d[63:56] = q[107:100];
        if (c == 4'h4 && q[111]) a = 7'h0C;
        r = "R5";
      end
      4'h5, 4'hD: begin
        d[15:0] = q[15:0]; d[31:16] = q[47:32]; d[63:32] = q[95:64];
        if (c == 4'h5 && q[111]) a = 7'h0D;
        r = "R5";
      end
      4'hA: begin d = 64'd0; d[63:56] = q[107:100]; end
      4'hE: begin a = q[70:64]; r = "R6"; end
      default: ;
    endcase
    return 1;
  endfunction

  task automatic model(logic [127:0] q);
    if (!m_busy) begin
      int loops, nr, cnt;
      loops = int'(q[14:0]);
      nr = (q[63:60] == 0) ? 16 : int'(q[63:60]);
      case (q[59:58])
        2'd0: cnt = loops * nr;
        2'd1: cnt = (loops * nr + 1) / 2;
        default: cnt = loops;
      endcase
      if (q[46]) push(1, 7'd0, {53'd0, q[57:47]}, "R2");
      m_regs = q[127:64]; m_nr = nr; m_idx = 0; m_eop = q[15];
      m_packed = (q[59:58] == 2'd0);
      if (cnt == 0) begin
        if (q[15]) push(2, 7'd0, 64'd0, "R10 R11");
      end else begin
        m_busy = 1; m_left = cnt;
      end
    end else begin
      if (m_packed) begin
        logic [6:0] a; logic [63:0] d; string r;
        if (ref_conv(m_regs[m_idx*4 +: 4], q, a, d, r)) push(0, a, d, {"R3 R12 ", r});
      end
      m_idx = (m_idx + 1) % m_nr;
      m_left--;
      if (m_left == 0) begin
        m_busy = 0;
        if (m_eop) push(2, 7'd0, 64'd0, "R11");
      end
    end
  endtask

  task automatic check_kind(int k, logic s, logic [6:0] a, logic [63:0] d);
    if (s) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_err++;
        $display("FAIL R7 R9 R10: unexpected strobe kind %0d addr %h data %h, expected none", k, a, d);
      end else begin
        ev_t e;
        e = expq.pop_front();
        if (e.kind != k || e.cyc != cyc || (k == 0 && e.addr != a) || e.data != d) begin
          n_err++;
          $display("FAIL %s: got kind %0d cyc %0d addr %h data %h, expected kind %0d cyc %0d addr %h data %h",
                   e.req, k, cyc, a, d, e.kind, e.cyc, e.addr, e.data);
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      check_kind(1, prim_en, 7'd0, {53'd0, prim_data});
      check_kind(0, wr_en, wr_addr, wr_data);
      check_kind(2, pkt_end, 7'd0, 64'd0);
      while (expq.size() > 0 && expq[0].cyc <= cyc) begin
        ev_t e;
        e = expq.pop_front();
        n_chk++; n_err++;
        $display("FAIL %s: missing strobe kind %0d addr %h data %h at cyc %0d, got none",
                 e.req, e.kind, e.addr, e.data, e.cyc);
      end
    end
  end

  function automatic logic [127:0] mktag(int loops, bit eop, bit pre, logic [10:0] prim,
                                         logic [1:0] flg, logic [3:0] nreg, logic [63:0] regs);
    return {regs, nreg, flg, prim, pre, 30'd0, eop, 15'(loops)};
  endfunction

  function automatic logic [127:0] pat(int s);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) r[i*32 +: 32] = (s * 32'h9E3779B1) ^ (i * 32'h85EBCA6B) ^ (s << i);
    return r;
  endfunction

  task automatic beat(logic [127:0] q, int gap);
    @(negedge clk);
    qw_valid = 1'b1;
    qw_data  = q;
    @(posedge clk);
    #1;
    model(q);
    if (gap > 0) begin
      @(negedge clk);
      qw_valid = 1'b0;
      repeat (gap - 1) @(posedge clk);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    qw_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not end, got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet outputs after reset; R12: ready high
    n_chk++;
    if (wr_en || prim_en || pkt_end || qw_ready !== 1'b1) begin
      n_err++;
      $display("FAIL R1: got wr %b prim %b end %b ready %b, expected 0 0 0 1",
               wr_en, prim_en, pkt_end, qw_ready);
    end
    run = 1;
    // R2 R3 R4 R5: preset, 2 loops of RGBAQ, XYZ2, XYZF2 (nibbles low first)
    beat(mktag(2, 1, 1, 11'h5A3, 2'd0, 4'd3, 64'h451), 0);
    for (int i = 0; i < 6; i++) beat(pat(10 + i), i % 2);
    // R6: address+data
    beat(mktag(1, 0, 0, 11'h0, 2'd0, 4'd3, 64'hEEE), 0);
    for (int i = 0; i < 3; i++) beat(pat(40 + i), 0);
    // R3 R7 R8: count 0 means 16, every code once
    beat(mktag(1, 1, 1, 11'h7FF, 2'd0, 4'd0, 64'hFEDCBA9876543210), 0);
    for (int i = 0; i < 16; i++) beat(pat(70 + i), (i == 5) ? 2 : 0);
    // R9: list mode 3x3 entries -> 5 quadwords
    beat(mktag(3, 0, 0, 11'h0, 2'd1, 4'd3, 64'h555), 0);
    for (int i = 0; i < 5; i++) beat(pat(100 + i), 0);
    // R9: image and reserved modes
    beat(mktag(2, 1, 0, 11'h0, 2'd2, 4'd0, 64'h111), 1);
    for (int i = 0; i < 2; i++) beat(pat(120 + i), 0);
    beat(mktag(1, 0, 0, 11'h0, 2'd3, 4'd1, 64'h1), 0);
    beat(pat(130), 0);
    // R10 R11: zero loops, with and without end flag
    beat(mktag(0, 1, 1, 11'h00C, 2'd0, 4'd2, 64'h51), 0);
    beat(mktag(0, 0, 0, 11'h0, 2'd0, 4'd2, 64'h51), 0);
    // R5 R7: XYZ2 then no-op, three loops
    beat(mktag(3, 1, 0, 11'h0, 2'd0, 4'd2, 64'hF5), 0);
    for (int i = 0; i < 6; i++) beat(pat(150 + i), 0);
    idle(10);
    // R3: every expected event consumed
    n_chk++;
    if (expq.size() != 0) begin
      n_err++;
      $display("FAIL R3: got %0d pending events, expected 0", expq.size());
    end
    finish_run();
  end
endmodule